// File: doc/BRIEF.md
# Strip Baseline Removal and 8-bit Rescaler

This block sits in the per-channel processing path of a strip detector readout. Each clock it may accept one digitised 10-bit sample, tagged with its channel index and with a flag marking it as a header word. For each channel it keeps an accumulator. The channel's baseline (pedestal) is read from that accumulator as a shift-based running average, and the accumulator learns from the incoming data while updating is enabled. In the first pipeline step the sample is optionally corrected by a signed per-strip header correction value, the channel's pedestal is optionally subtracted, and the accumulator is updated. In the second step the signed difference is offset by a bias and saturated into an unsigned 8-bit output word.

The averaging length is a power of two chosen at run time through a shift-amount input. The enables for update, subtraction, header correction and suppression are level inputs and are sampled together with each sample. Header words never feed the learning accumulator. When suppression is on, header words are also removed from the output stream.

Top module: `pedsub_rescale`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0, and every channel's accumulator is 0, so every pedestal reads 0.
- R2: An input accepted at clock edge k and not dropped gives out_valid high for exactly one cycle after edge k+2. A cycle with in_valid low gives no output two edges later. out_data holds its value while out_valid is low.
- R3: When sub_en is high, the difference is the corrected sample minus the channel's pedestal. The pedestal is taken before this sample's own update and is min(acc >> avg_shift, 1023).
- R4: When sub_en is low, the difference equals the corrected sample and no pedestal is subtracted.
- R5: When hdr_en is high, the corrected sample is in_sample minus hdr_corr, where hdr_corr is read as a signed two's-complement 10-bit value. When hdr_en is low, the corrected sample equals in_sample.
- R6: out_data = clamp(difference + 128, 0, 255): a sum below 0 gives 0 and a sum above 255 gives 255.
- R7: When in_valid and upd_en are high and in_header is low, the channel's accumulator becomes acc - pedestal + in_sample, using the raw sample.
- R8: With upd_en low, no accumulator changes, so later outputs of that channel still use the old pedestal.
- R9: A header word (in_header high) never changes an accumulator. With zs_en high it produces no output. With zs_en low it passes through like data.
- R10: avg_shift sets the averaging length N = 2^avg_shift, and a change takes effect on the next sample.
- R11: Samples of the same channel on back-to-back cycles each see the pedestal that the previous sample left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | 10 | Digitised strip sample |
| in_chan | input | 4 | Channel index selecting the pedestal entry |
| in_header | input | 1 | Sample is a header word |
| hdr_corr | input | 10 | Signed header correction for this strip |
| avg_shift | input | 3 | log2 of the averaging length |
| upd_en | input | 1 | Allow pedestal learning |
| sub_en | input | 1 | Subtract the pedestal |
| hdr_en | input | 1 | Apply the header correction |
| zs_en | input | 1 | Remove header words from the output |
| out_valid | output | 1 | Output word valid |
| out_data | output | 8 | Rescaled 8-bit sample |

## Verification
The assertions check, on every cycle, the two-step timing of valid and idle slots, the removal of header words under suppression, the saturation at both ends of the output range, the pass-through when nothing is subtracted, and the rule that an accumulator entry changes only when it is written. The numerical value of each learned pedestal is left to the bench's reference model: how it converges over many events, how it reacts to a new averaging length, and what a later subtraction gives after learning was frozen. The model is checked against the outputs on every clock, through long same-channel runs, interleaved channels and random enable mixes.

// File: rtl/pedsub_pkg.sv
package pedsub_pkg;
  localparam int SMP_W  = 10;
  localparam int OUT_W  = 8;
  localparam int DIFF_W = SMP_W + 2;

  typedef struct packed {
    logic                     vld;
    logic signed [DIFF_W-1:0] diff;
  } s1_t;
endpackage

// File: rtl/pedsub_ped_mem.sv
module pedsub_ped_mem
  import pedsub_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int SH_W = 3,
  localparam int CH_W  = $clog2(NCH),
  localparam int ACC_W = SMP_W + (1 << SH_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  chan,
  input  logic [SH_W-1:0]  shift,
  input  logic             we,
  input  logic [SMP_W-1:0] wsample,
  output logic [SMP_W-1:0] ped
);
  localparam logic [ACC_W-1:0] MAXP = ACC_W'((1 << SMP_W) - 1);

  logic [ACC_W-1:0] acc_q [NCH];
  logic [ACC_W-1:0] acc_d [NCH];
  logic [ACC_W-1:0] shifted;
  logic [ACC_W:0]   sum;

  always_comb begin
    shifted = acc_q[chan] >> shift;
    ped     = (shifted > MAXP) ? SMP_W'(MAXP) : shifted[SMP_W-1:0];
  end

  always_comb begin
    sum = {1'b0, acc_q[chan]} - (ACC_W+1)'(ped) + (ACC_W+1)'(wsample);
    for (int i = 0; i < NCH; i++) acc_d[i] = acc_q[i];
    if (we) acc_d[chan] = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) acc_q[i] <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) acc_q[i] <= acc_d[i];
    end
  end

  // R8: an entry that is not written keeps its value
  for (genvar g = 0; g < NCH; g++) begin : g_hold
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && chan == CH_W'(g)) |=> $stable(acc_q[g]))
      else $error("accumulator %0d changed without a write", g);
  end
endmodule

// File: rtl/pedsub_sub_stage.sv
module pedsub_sub_stage
  import pedsub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_in,
  input  logic             drop,
  input  logic [SMP_W-1:0] sample,
  input  logic [SMP_W-1:0] corr,
  input  logic [SMP_W-1:0] ped,
  input  logic             hdr_en,
  input  logic             sub_en,
  output s1_t              s1
);
  logic signed [DIFF_W-1:0] samp_s, corr_s, ped_s, fixed_s;
  s1_t s1_d, s1_q;

  always_comb begin
    samp_s  = $signed({2'b00, sample});
    corr_s  = $signed({{2{corr[SMP_W-1]}}, corr});
    ped_s   = $signed({2'b00, ped});
    fixed_s = hdr_en ? samp_s - corr_s : samp_s;
    s1_d.vld  = v_in && !drop;
    s1_d.diff = s1_q.diff;
    if (v_in) s1_d.diff = sub_en ? fixed_s - ped_s : fixed_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_q <= '0;
    else        s1_q <= s1_d;
  end

  assign s1 = s1_q;

  // R4: with neither correction nor subtraction the raw sample passes
  p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    v_in && !sub_en && !hdr_en |=> s1_q.diff == $signed({2'b00, $past(sample)}))
    else $error("unsubtracted difference differs from sample");
endmodule

// File: rtl/pedsub_scale_stage.sv
module pedsub_scale_stage
  import pedsub_pkg::*;
#(
  parameter int BIAS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  s1_t              s1,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int MAXO = (1 << OUT_W) - 1;
  localparam int HI   = MAXO - BIAS;
  localparam int LO   = -BIAS;

  logic signed [DIFF_W:0] bias_s, biased;
  logic [OUT_W-1:0] sat, data_d, data_q;
  logic             v_d, v_q;

  assign bias_s = BIAS[DIFF_W:0];

  always_comb begin
    biased = {s1.diff[DIFF_W-1], s1.diff} + bias_s;
    if (biased < 0)         sat = '0;
    else if (biased > MAXO) sat = OUT_W'(MAXO);
    else                    sat = biased[OUT_W-1:0];
    v_d    = s1.vld;
    data_d = s1.vld ? sat : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      data_q <= '0;
    end else begin
      v_q    <= v_d;
      data_q <= data_d;
    end
  end

  assign out_valid = v_q;
  assign out_data  = data_q;

  p_sat_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s1.vld && s1.diff > HI |=> out_data == OUT_W'(MAXO))
    else $error("upper saturation missed");
  p_sat_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s1.vld && s1.diff < LO |=> out_data == '0)
    else $error("lower saturation missed");
endmodule

// File: rtl/pedsub_rescale.sv
module pedsub_rescale
  import pedsub_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int SH_W = 3,
  parameter int BIAS = 128,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_sample,
  input  logic [CH_W-1:0]  in_chan,
  input  logic             in_header,
  input  logic [SMP_W-1:0] hdr_corr,
  input  logic [SH_W-1:0]  avg_shift,
  input  logic             upd_en,
  input  logic             sub_en,
  input  logic             hdr_en,
  input  logic             zs_en,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  logic [SMP_W-1:0] ped;
  logic             mem_we;
  logic             drop;
  s1_t              s1;

  assign mem_we = in_valid && upd_en && !in_header;
  assign drop   = in_header && zs_en;

  pedsub_ped_mem #(.NCH(NCH), .SH_W(SH_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .chan(in_chan), .shift(avg_shift),
    .we(mem_we), .wsample(in_sample), .ped(ped)
  );

  pedsub_sub_stage u_sub (
    .clk(clk), .rst_n(rst_n), .v_in(in_valid), .drop(drop),
    .sample(in_sample), .corr(hdr_corr), .ped(ped),
    .hdr_en(hdr_en), .sub_en(sub_en), .s1(s1)
  );

  pedsub_scale_stage #(.BIAS(BIAS)) u_scale (
    .clk(clk), .rst_n(rst_n), .s1(s1),
    .out_valid(out_valid), .out_data(out_data)
  );

  p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !drop |-> ##2 out_valid)
    else $error("accepted sample did not emerge after two edges");
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid)
    else $error("output appeared for an idle slot");
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_header && zs_en |-> ##2 !out_valid)
    else $error("suppressed header reached the output");
  p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> out_valid || $stable(out_data))
    else $error("output word moved without valid");
endmodule

// File: tb/sim_pedsub_rescale.sv
module sim_pedsub_rescale;
  localparam int TCLK = 10;
  localparam int NCH  = 16;
  localparam int SH_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_header, upd_en, sub_en, hdr_en, zs_en;
  logic [9:0] in_sample, hdr_corr;
  logic [3:0] in_chan;
  logic [2:0] avg_shift;
  logic out_valid;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  bit done = 0;
  int acc [NCH];
  bit    m1_v = 0, mo_v = 0;
  int    m1_d = 0, mo_d = 0;
  string m1_t = "R1", mo_t = "R1";

  always #(TCLK/2) clk = ~clk;

  pedsub_rescale #(.NCH(NCH), .SH_W(SH_W), .BIAS(128)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_chan(in_chan), .in_header(in_header), .hdr_corr(hdr_corr),
    .avg_shift(avg_shift), .upd_en(upd_en), .sub_en(sub_en), .hdr_en(hdr_en),
    .zs_en(zs_en), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int s, int ch, bit hdr, bit upd, bit sub,
                      bit hen, int hc, bit zs, int k, string tag);
    int p, d;
    in_valid = v; in_sample = 10'(s); in_chan = 4'(ch); in_header = hdr;
    upd_en = upd; sub_en = sub; hdr_en = hen; hdr_corr = 10'(hc);
    zs_en = zs; avg_shift = 3'(k);
    @(posedge clk);
    mo_v = m1_v; mo_t = m1_t;
    if (m1_v) mo_d = m1_d;
    p = acc[ch] >> k;
    if (p > 1023) p = 1023;
    d = hen ? s - hc : s;
    if (sub) d = d - p;
    d = d + 128;
    if (d < 0) d = 0;
    if (d > 255) d = 255;
    m1_v = v && !(hdr && zs);
    m1_d = d;
    m1_t = tag;
    if (v && upd && !hdr) acc[ch] = acc[ch] - p + s;
    @(negedge clk);
    chk(out_valid == mo_v, {mo_t, " valid"}, out_valid, mo_v);
    if (mo_v) chk(out_data == 8'(mo_d), {mo_t, " data"}, out_data, mo_d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) acc[i] = 0;
    rst_n = 0; in_valid = 0; in_sample = 0; in_chan = 0; in_header = 0;
    upd_en = 0; sub_en = 0; hdr_en = 0; hdr_corr = 0; zs_en = 0; avg_shift = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    chk(out_data == 8'd0, "R1 data after reset", out_data, 0);
    // R1: fresh pedestal is zero
    step(1, 60, 5, 0, 0, 1, 0, 0, 0, 3, "R1 zero pedestal");
    // R4 / R6: no subtraction, mid and saturating values
    step(1, 50, 1, 0, 0, 0, 0, 0, 0, 0, "R4 pass");
    step(1, 200, 2, 0, 0, 0, 0, 0, 0, 0, "R6 high clamp");
    step(1, 127, 2, 0, 0, 0, 0, 0, 0, 0, "R6 top edge");
    step(1, 128, 2, 0, 0, 0, 0, 0, 0, 0, "R6 just over");
    // R5: header correction, both signs, low clamp
    step(1, 10, 3, 0, 0, 0, 1, 300, 0, 0, "R5 R6 low clamp");
    step(1, 10, 3, 0, 0, 0, 1, -20, 0, 0, "R5 negative corr");
    step(1, 140, 3, 0, 0, 0, 1, 12, 0, 0, "R5 positive corr");
    idle(3);
    // R7 / R11 / R10: learning on one channel back to back, N = 4
    for (int i = 0; i < 40; i++)
      step(1, 400 + (i % 3), 7, 0, 1, 1, 0, 0, 0, 2, "R7 R11 learn");
    step(1, 405, 7, 0, 0, 1, 0, 0, 0, 2, "R3 after learning");
    // R8: frozen pedestal ignores big samples
    for (int i = 0; i < 6; i++)
      step(1, 900, 7, 0, 0, 1, 0, 0, 0, 2, "R8 frozen");
    step(1, 398, 7, 0, 0, 1, 0, 0, 0, 2, "R8 old pedestal");
    // R10: change averaging length
    step(1, 400, 7, 0, 0, 1, 0, 0, 0, 0, "R10 shift 0 saturates");
    step(1, 400, 7, 0, 0, 1, 0, 0, 0, 7, "R10 shift 7");
    for (int i = 0; i < 10; i++)
      step(1, 1000, 8, 0, 1, 1, 0, 0, 0, 1, "R10 R11 N=2");
    // R9: headers
    step(1, 700, 7, 1, 1, 1, 0, 0, 1, 2, "R9 suppressed header");
    step(1, 700, 7, 1, 1, 1, 0, 0, 0, 2, "R9 header passes");
    step(1, 400, 7, 0, 0, 1, 0, 0, 0, 2, "R9 header no learn");
    idle(2);
    // mixed traffic over all channels
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom;
      step(r[0] | r[1], $urandom_range(0, 1023), $urandom_range(0, NCH-1),
           r[2] & r[3], r[4] | r[5], r[6] | r[7], r[8], $urandom_range(0, 1023) - 512,
           r[9], $urandom_range(0, 7), "R3 R7 mixed");
    end
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule